// File: doc/BRIEF.md
# Interval Timer Bank

This block holds six independent down-counting timers behind a small memory-mapped register port. Every access on that port moves a full 32-bit word. Each channel takes one of four external tick strobes and slows it by a power of two. It counts down once per slowed tick and flags an expiry when the count reaches zero. A channel either reloads and keeps running (periodic) or stops and drops its own run bit (single-shot).

Expiry events collect in a shared status register, which is cleared by writing ones. A shared enable register masks the status, and one interrupt line per channel carries the result. Software programs the interval first, then writes the control word with the reload and run bits set. After that it services interrupts by reading the status and writing ones back to it.

Top module: `interval_timer_bank`

## Requirements
- R1: Six channels exist. Channel i has a control, an interval and a count register in address slot i+1, so the slot field bus_addr[7:4] minus one gives the channel.
- R2: Within a slot, bus_addr[3:0] = 0x0 selects control, 0x4 selects interval and 0x8 selects count. Address 0x00 is the interrupt enable register and 0x04 is the interrupt status register, each using bits [5:0] with bit i for channel i.
- R3: Control bits [3:2] select which tick_src strobe feeds the channel. Strobes on the other three inputs leave the count unchanged.
- R4: Control bits [6:4] hold an exponent n. The count moves once per 2^n selected strobes, and the division phase restarts on every control write.
- R5: A control write stores bits [7:0]. If bit 1 (reload) is set, it copies the interval into the count. Bit 0 (run) starts the channel; with run clear, the channel holds its count and ignores strobes.
- R6: With control bit 7 set (single-shot), reaching zero sets the status bit and clears control bit 0 in hardware. The count then stays at zero.
- R7: A running periodic channel decrements on each divided tick and sets its status bit when the count reaches zero. The next divided tick reloads the interval, and the channel keeps running.
- R8: irq_out[i] equals status[i] AND enable[i]. It changes on the same clock edge as the register that changed it.
- R9: A write to the status register clears every bit written as 1 and leaves the other bits unchanged.
- R10: Reset clears enable, status and irq_out. It zeroes every interval and count and loads every control register with 0x04 (source 1, exponent 0, stopped, periodic).
- R11: An interval write changes only the reload value, not the live count. Writes to the count register are ignored.
- R12: Read data is registered and appears on bus_rdata in the cycle after bus_rd. Unmapped addresses read as zero, and a count read returns the live counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| tick_src | input | 4 | Four tick-enable strobes, one cycle wide each |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 6 | Interrupt line per channel |

## Verification
A wrong count shows up at the ports in two ways. A count read returns it one cycle after the request. The status bit, and with the enable set the interrupt line, also moves one divided tick early or late. A stuck prescaler phase or a wrong source selection shows as a count that has not moved after the strobes that should have moved it. A run bit that single-shot expiry fails to clear shows on the next strobe, when the channel would reload if its mode were misread. A bad status or enable bit reaches irq_out on the very edge of the access that set it.

// File: rtl/itb_pkg.sv
package itb_pkg;
  localparam int CTL_W     = 8;
  localparam int B_RUN     = 0;
  localparam int B_RELOAD  = 1;
  localparam int B_SRC_LO  = 2;
  localparam int B_EXP_LO  = 4;
  localparam int B_ONESHOT = 7;

  localparam logic [CTL_W-1:0] CTL_RESET = 8'h04;

  localparam logic [3:0] SEL_CTL = 4'h0;
  localparam logic [3:0] SEL_IVL = 4'h4;
  localparam logic [3:0] SEL_CNT = 4'h8;

  localparam logic [7:0] OFS_IEN = 8'h00;
  localparam logic [7:0] OFS_IST = 8'h04;
endpackage

// File: rtl/itb_prescaler.sv
module itb_prescaler #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             ptick
);
  localparam int PW = (1 << EXP_W) - 1;

  logic [PW-1:0] ph_q;
  logic [PW-1:0] mask;

  always_comb begin
    mask  = ~({PW{1'b1}} << exp_sel);
    ptick = tick && ((ph_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) ph_q <= '0;
    else if (tick)  ph_q <= ptick ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/itb_channel.sv
module itb_channel
  import itb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 2,
  parameter int EXP_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic                 ivl_we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [(1<<SRC_W)-1:0] tick_src,
  output logic [CTL_W-1:0]     ctl_q,
  output logic [CNT_W-1:0]     ivl_q,
  output logic [CNT_W-1:0]     cnt_q,
  output logic                 expire
);
  logic sel_tick, gated, ptick;

  always_comb begin
    sel_tick = tick_src[ctl_q[B_SRC_LO +: SRC_W]];
    gated    = sel_tick && ctl_q[B_RUN] && !ctl_we;
    expire   = ptick && (cnt_q == CNT_W'(1));
  end

  itb_prescaler #(.EXP_W(EXP_W)) i_pre (
    .clk     (clk),
    .rst     (rst),
    .clr     (ctl_we),
    .tick    (gated),
    .exp_sel (ctl_q[B_EXP_LO +: EXP_W]),
    .ptick   (ptick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RESET;
      ivl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ivl_we) ivl_q <= wdata[CNT_W-1:0];
      if (ctl_we) begin
        ctl_q <= wdata[CTL_W-1:0];
        if (wdata[B_RELOAD]) cnt_q <= ivl_q;
      end else if (ptick) begin
        if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
        else if (!ctl_q[B_ONESHOT]) cnt_q <= ivl_q;
        if (expire && ctl_q[B_ONESHOT]) ctl_q[B_RUN] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
  import itb_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SRC_W  = 2,
  parameter int EXP_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [(1<<SRC_W)-1:0] tick_src,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NCH-1:0]        irq_out
);
  localparam int NSRC = 1 << SRC_W;

  logic [3:0]       slot, sel;
  logic [CTL_W-1:0] ctl_a [NCH];
  logic [CNT_W-1:0] ivl_a [NCH];
  logic [CNT_W-1:0] cnt_a [NCH];
  logic [NCH-1:0]   exp_v, oneshot_v, run_v;
  logic [NCH-1:0]   en_q, stat_q, en_nxt, stat_nxt, clr_mask;
  logic [DATA_W-1:0] rd_mux;

  assign slot = bus_addr[7:4];
  assign sel  = bus_addr[3:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit          = bus_wr && (slot == 4'(i + 1));
    assign oneshot_v[i] = ctl_a[i][B_ONESHOT];
    assign run_v[i]     = ctl_a[i][B_RUN];

    itb_channel #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .EXP_W(EXP_W)
    ) i_ch (
      .clk      (clk),
      .rst      (rst),
      .ctl_we   (hit && (sel == SEL_CTL)),
      .ivl_we   (hit && (sel == SEL_IVL)),
      .wdata    (bus_wdata),
      .tick_src (tick_src[NSRC-1:0]),
      .ctl_q    (ctl_a[i]),
      .ivl_q    (ivl_a[i]),
      .cnt_q    (cnt_a[i]),
      .expire   (exp_v[i])
    );
  end

  always_comb begin
    clr_mask = (bus_wr && bus_addr == OFS_IST) ? bus_wdata[NCH-1:0] : '0;
    en_nxt   = (bus_wr && bus_addr == OFS_IEN) ? bus_wdata[NCH-1:0] : en_q;
    stat_nxt = (stat_q & ~clr_mask) | exp_v;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_IEN) rd_mux = DATA_W'(en_q);
    else if (bus_addr == OFS_IST) rd_mux = DATA_W'(stat_q);
    else begin
      for (int i = 0; i < NCH; i++) begin
        if (slot == 4'(i + 1)) begin
          case (sel)
            SEL_CTL: rd_mux = DATA_W'(ctl_a[i]);
            SEL_IVL: rd_mux = DATA_W'(ivl_a[i]);
            SEL_CNT: rd_mux = DATA_W'(cnt_a[i]);
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      stat_q    <= '0;
      irq_out   <= '0;
      bus_rdata <= '0;
    end else begin
      en_q    <= en_nxt;
      stat_q  <= stat_nxt;
      irq_out <= stat_nxt & en_nxt;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/itb_checker.sv
module itb_checker
  import itb_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCH-1:0]    irq_out,
  input logic [NCH-1:0]    en_q,
  input logic [NCH-1:0]    stat_q,
  input logic [NCH-1:0]    exp_v,
  input logic [NCH-1:0]    oneshot_v,
  input logic [NCH-1:0]    run_v
);
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == (stat_q & en_q));

  // R10
  irq_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (irq_out == '0 && stat_q == '0 && en_q == '0));

  // R9
  status_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_IST) |=>
      ((stat_q & $past(bus_wdata[NCH-1:0]) & ~$past(exp_v)) == '0));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ((exp_v & oneshot_v) != '0) |=> ((run_v & $past(exp_v & oneshot_v)) == '0));

  // R7
  expiry_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    (exp_v != '0) |=> ((stat_q & $past(exp_v)) == $past(exp_v)));

  // R12
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[3:0] == 4'hC) |=> (bus_rdata == '0));
endmodule

bind interval_timer_bank itb_checker #(
  .NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .en_q      (en_q),
  .stat_q    (stat_q),
  .exp_v     (exp_v),
  .oneshot_v (oneshot_v),
  .run_v     (run_v)
);

// File: tb/test_interval_timer_bank.sv
`timescale 1ns/1ps
module test_interval_timer_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  tick_src = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  irq_out;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  interval_timer_bank i_interval_timer_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tick_src(tick_src),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic tick(input logic [3:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_src = m;
      @(negedge clk); tick_src = 4'h0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R10 irq after reset", 32'(irq_out), 0);
    rd(8'h10, v); chk("R10 ch0 control default", v, 32'h04);
    rd(8'h64, v); chk("R10 ch5 interval zero", v, 0);
    rd(8'h38, v); chk("R10 ch2 count zero", v, 0);
    rd(8'h00, v); chk("R10 enable zero", v, 0);
    rd(8'h04, v); chk("R10 status zero", v, 0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(8'h14, 3); wr(8'h10, 32'h07);
    rd(8'h18, v); chk("R5 reload copies interval", v, 3);
    tick(4'b0010, 2);
    rd(8'h18, v); chk("R7 decrement per tick", v, 1);
    tick(4'b0010, 1);
    rd(8'h04, v); chk("R7 status on zero", v, 32'h01);
    chk("R8 irq masked while disabled", 32'(irq_out), 0);
    wr(8'h00, 32'h01);
    chk("R8 irq rises on enable write", 32'(irq_out), 32'h01);
    tick(4'b0010, 1);
    rd(8'h18, v); chk("R7 periodic reload", v, 3);
    wr(8'h04, 32'h01);
    chk("R8 irq falls on status clear", 32'(irq_out), 0);
    tick(4'b0010, 3);
    chk("R7 second period expiry", 32'(irq_out), 32'h01);
    rd(8'h10, v); chk("R7 still running", v, 32'h07);
    wr(8'h10, 32'h04); tick(4'b0010, 2);
    rd(8'h18, v); chk("R5 stopped channel holds", v, 0);
  endtask

  task automatic t_source;
    logic [31:0] v;
    wr(8'h24, 5); wr(8'h20, 32'h0B);
    tick(4'b1011, 3);
    rd(8'h28, v); chk("R3 other sources ignored", v, 5);
    tick(4'b0100, 1);
    rd(8'h28, v); chk("R3 selected source counts", v, 4);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(8'h34, 2); wr(8'h30, 32'h23);
    tick(4'b0001, 3);
    rd(8'h38, v); chk("R4 held before 2^n strobes", v, 2);
    tick(4'b0001, 1);
    rd(8'h38, v); chk("R4 moves on 4th strobe", v, 1);
    tick(4'b0001, 4);
    rd(8'h04, v); chk("R4 expiry after divided ticks", v & 32'h04, 32'h04);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(8'h44, 2); wr(8'h40, 32'h87);
    tick(4'b0010, 2);
    rd(8'h40, v); chk("R6 run bit cleared", v, 32'h86);
    rd(8'h04, v); chk("R6 status set", v & 32'h08, 32'h08);
    tick(4'b0010, 2);
    rd(8'h48, v); chk("R6 count stays zero", v, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(8'h04, 32'h04);
    rd(8'h04, v); chk("R9 only written ones cleared", v, 32'h09);
  endtask

  task automatic t_slot;
    logic [31:0] v;
    wr(8'h00, 32'h20);
    wr(8'h64, 1); wr(8'h60, 32'h07);
    tick(4'b0010, 1);
    chk("R1 slot 6 is channel 5", 32'(irq_out), 32'h20);
    rd(8'h58, v); chk("R2 slot 5 untouched", v, 0);
    rd(8'h60, v); chk("R2 control offset", v, 32'h07);
  endtask

  task automatic t_ivl_cnt;
    logic [31:0] v;
    wr(8'h28, 99);
    rd(8'h28, v); chk("R11 count write ignored", v, 4);
    wr(8'h24, 9);
    rd(8'h28, v); chk("R11 interval leaves count", v, 4);
    wr(8'h20, 32'h0B);
    rd(8'h28, v); chk("R11 new interval on reload", v, 9);
    rd(8'hF0, v); chk("R12 unmapped slot reads zero", v, 0);
    rd(8'h1C, v); chk("R12 unmapped offset reads zero", v, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset(); t_periodic(); t_source(); t_prescale();
    t_oneshot(); t_w1c(); t_slot(); t_ivl_cnt();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule